// File: doc/BRIEF.md
# Buffered Stereo Audio Channel Router

This block takes stereo PCM sample pairs from an upstream serial-audio receiver and holds them in a small FIFO. It drains that FIFO once per output sample period, on a single-cycle strobe from a fixed-rate timebase. Because of the FIFO, the producer may deliver pairs at any rate equal to or above the output rate. A producer that runs faster simply stalls on backpressure while the FIFO is full.

Each output channel has its own two-bit source code. The code picks digital silence, the stored left sample or the stored right sample. The selection is applied when a pair leaves the FIFO, so channel swap, mono duplication and muting switch cleanly on sample boundaries.

Left and right are kept together as one FIFO entry, so they can never drift apart. If the FIFO is empty when a strobe arrives, both outputs go to zero and a sticky underflow flag is raised.

Top module: `audio_route_buffer`

## Requirements
- R1: After a synchronous active-low reset, `out_left`, `out_right`, `underflow` and `drop_count` are zero and `in_ready` is 1.
- R2: On each `out_strobe` that pops a pair, `out_left` takes a value set by `sel_left`: 2'b00 gives zero, 2'b01 gives the stored left sample, 2'b10 gives the stored right sample, and 2'b11 gives zero.
- R3: `out_right` follows the same code table using `sel_right`, independently of `sel_left`.
- R4: Pairs leave in the order they were accepted. A popped pair's left and right samples come from the same accepted input cycle.
- R5: `out_left` and `out_right` change only in the cycle after an `out_strobe`. A change to either select between strobes has no effect until the next strobe.
- R6: A pair is accepted when `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly while DEPTH pairs are stored.
- R7: A write attempted while `in_ready` is 0 is discarded, even if a strobe pops in the same cycle. Each such attempt increments `drop_count`, which saturates at its maximum.
- R8: An `out_strobe` while the FIFO is empty drives both outputs to zero and sets `underflow`. `underflow` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a stereo pair |
| in_ready | output | 1 | FIFO can accept a pair |
| in_left | input | SAMPLE_W | Incoming left sample |
| in_right | input | SAMPLE_W | Incoming right sample |
| out_strobe | input | 1 | One-cycle pulse at the output sample rate |
| sel_left | input | 2 | Source code for the left output |
| sel_right | input | 2 | Source code for the right output |
| out_left | output | SAMPLE_W | Registered left output sample |
| out_right | output | SAMPLE_W | Registered right output sample |
| underflow | output | 1 | Sticky flag: a strobe found the FIFO empty |
| drop_count | output | DROP_W | Saturating count of writes refused while full |

## Verification
The assertions assume that reset is held for at least one clock edge and that `out_strobe` is a clean synchronous pulse. They place no limit on how often `in_valid` may be high, and the stimulus keeps to these conditions. Inputs are driven on the falling edge, and strobes are single-cycle pulses. The stimulus deliberately keeps offering writes into a full FIFO and strobes an empty one, so the drop-count and underflow properties are exercised on their boundaries rather than trivially disabled.

// File: rtl/audio_route_pkg.sv
// Shared types for the stereo channel router.
// Assumes: callers cast the raw 2-bit select ports to src_sel_e.
package audio_route_pkg;
    typedef enum logic [1:0] {
        SRC_MUTE   = 2'b00,
        SRC_LEFT   = 2'b01,
        SRC_RIGHT  = 2'b10,
        SRC_MUTE_X = 2'b11
    } src_sel_e;
endpackage

// File: rtl/pair_fifo.sv
// Paired-sample FIFO: each entry holds one left and one right sample together.
// Assumes: DEPTH is a power of two, and pop is only raised when not empty.
module pair_fifo #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [2*SAMPLE_W-1:0] wr_pair,
    input  logic                  pop,
    output logic [2*SAMPLE_W-1:0] rd_pair,
    output logic                  full,
    output logic                  empty
);
    localparam int AW = $clog2(DEPTH);

    logic [2*SAMPLE_W-1:0] mem [DEPTH];
    logic [AW:0] wr_ptr, rd_ptr;
    logic        do_wr, do_rd;

    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty   = (wr_ptr == rd_ptr);
    assign rd_pair = mem[rd_ptr[AW-1:0]];

    // Store an accepted pair at the write slot.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_pair;
    end

    // Advance the wrap-tagged pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R7: a push into a full FIFO leaves the write pointer where it was.
    assert_full_push_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (wr_ptr == $past(wr_ptr)));

    // R6: a lone accepted push makes the FIFO non-empty.
    assert_push_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> !empty);

    // R4: a lone pop from a single-entry FIFO empties it.
    assert_pop_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && (wr_ptr == rd_ptr + 1'b1)) |=> empty);
endmodule

// File: rtl/chan_mux.sv
// Source selector for one output channel: silence, left or right sample.
// Assumes: the code 11 is treated as silence.
module chan_mux
    import audio_route_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  src_sel_e              sel,
    input  logic [SAMPLE_W-1:0]   left_in,
    input  logic [SAMPLE_W-1:0]   right_in,
    output logic [SAMPLE_W-1:0]   y
);
    // Pick the channel source for this output.
    always_comb begin
        unique case (sel)
            SRC_LEFT:  y = left_in;
            SRC_RIGHT: y = right_in;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/audio_route_buffer.sv
// Buffered stereo router: a FIFO decouples input rate from the strobed output
// rate; per-channel muxes pick the source, sampled only at the output strobe.
// Assumes: out_strobe is a one-cycle pulse; reset lasts at least one edge.
module audio_route_buffer
    import audio_route_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 8,
    parameter int DROP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                out_strobe,
    input  logic [1:0]          sel_left,
    input  logic [1:0]          sel_right,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                underflow,
    output logic [DROP_W-1:0]   drop_count
);
    localparam int NCH = 2;

    logic [2*SAMPLE_W-1:0] head_pair;
    logic                  fifo_full, fifo_empty;
    src_sel_e              sel_arr [NCH];
    logic [SAMPLE_W-1:0]   mux_y   [NCH];
    logic [SAMPLE_W-1:0]   out_q   [NCH];

    assign in_ready   = !fifo_full;
    assign sel_arr[0] = src_sel_e'(sel_left);
    assign sel_arr[1] = src_sel_e'(sel_right);
    assign out_left   = out_q[0];
    assign out_right  = out_q[1];

    pair_fifo #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (in_valid),
        .wr_pair ({in_left, in_right}),
        .pop     (out_strobe),
        .rd_pair (head_pair),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
            .sel      (sel_arr[c]),
            .left_in  (head_pair[2*SAMPLE_W-1:SAMPLE_W]),
            .right_in (head_pair[SAMPLE_W-1:0]),
            .y        (mux_y[c])
        );

        // Latch this channel's sample on the strobe; zero on underflow.
        always_ff @(posedge clk) begin
            if (!rst_n)          out_q[c] <= '0;
            else if (out_strobe) out_q[c] <= fifo_empty ? '0 : mux_y[c];
        end
    end

    // Sticky underflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        underflow <= 1'b0;
        else if (out_strobe && fifo_empty) underflow <= 1'b1;
    end

    // Saturating count of writes refused while full.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         drop_count <= '0;
        else if (in_valid && fifo_full && drop_count != '1) drop_count <= drop_count + 1'b1;
    end

    // R5: outputs hold between strobes.
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_strobe |=> ($stable(out_left) && $stable(out_right)));

    // R8: a strobe on an empty FIFO gives silence and sets the flag.
    assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && fifo_empty) |=> (out_left == '0 && out_right == '0 && underflow));

    // R8: the underflow flag is sticky.
    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R7: a refused write bumps the drop counter unless saturated.
    assert_drop_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && drop_count != '1) |=> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: tb/tb_audio_route_buffer.sv
`timescale 1ns/1ps
module tb_audio_route_buffer;
    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_left, in_right;
    logic         out_strobe;
    logic [1:0]   sel_left, sel_right;
    logic [W-1:0] out_left, out_right;
    logic         underflow;
    logic [7:0]   drop_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    audio_route_buffer #(.SAMPLE_W(W), .DEPTH(DEPTH), .DROP_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .out_strobe(out_strobe),
        .sel_left(sel_left), .sel_right(sel_right), .out_left(out_left),
        .out_right(out_right), .underflow(underflow), .drop_count(drop_count)
    );

    // Vector: {sel_left, sel_right, left sample, right sample}
    localparam logic [35:0] VEC [10] = '{
        {2'b01, 2'b10, 16'h1111, 16'h2222},
        {2'b10, 2'b01, 16'h3333, 16'h4444},
        {2'b01, 2'b01, 16'h5555, 16'h6666},
        {2'b10, 2'b10, 16'h7777, 16'h8888},
        {2'b00, 2'b01, 16'h9999, 16'hAAAA},
        {2'b10, 2'b00, 16'hBBBB, 16'hCCCC},
        {2'b11, 2'b10, 16'hDDDD, 16'hEEEE},
        {2'b01, 2'b11, 16'h0F0F, 16'hF0F0},
        {2'b11, 2'b11, 16'h1234, 16'h5678},
        {2'b00, 2'b00, 16'hFFFF, 16'h0001}
    };

    function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] l, input logic [W-1:0] r);
        case (s)
            2'b01:   return l;
            2'b10:   return r;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
        out_strobe = 1'b0; sel_left = 2'b01; sel_right = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_left", 32'(out_left), 32'h0);
        check("R1 out_right", 32'(out_right), 32'h0);
        check("R1 underflow", 32'(underflow), 32'h0);
        check("R1 drop_count", 32'(drop_count), 32'h0);
        check("R1 in_ready", 32'(in_ready), 32'h1);

        // R2 / R3 table walk
        for (int i = 0; i < 10; i++) begin
            sel_left  = VEC[i][35:34];
            sel_right = VEC[i][33:32];
            push(VEC[i][31:16], VEC[i][15:0]);
            strobe();
            check("R2 left select", 32'(out_left), 32'(pick(VEC[i][35:34], VEC[i][31:16], VEC[i][15:0])));
            check("R3 right select", 32'(out_right), 32'(pick(VEC[i][33:32], VEC[i][31:16], VEC[i][15:0])));
        end

        // R5: select change between strobes is not visible until next strobe
        sel_left = 2'b01; sel_right = 2'b10;
        push(16'hA001, 16'hB001);
        push(16'hA002, 16'hB002);
        strobe();
        sel_left = 2'b10; sel_right = 2'b01;
        repeat (3) @(negedge clk);
        check("R5 left hold", 32'(out_left), 32'hA001);
        check("R5 right hold", 32'(out_right), 32'hB001);
        strobe();
        check("R5 left after strobe", 32'(out_left), 32'hB002);
        check("R5 right after strobe", 32'(out_right), 32'hA002);

        // R4 ordering and pairing; R6 fill to full
        sel_left = 2'b01; sel_right = 2'b10;
        for (int i = 0; i < DEPTH; i++) push(16'(16'hC000 + i), 16'(16'hD000 + i));
        check("R6 in_ready low when full", 32'(in_ready), 32'h0);
        // R7: two refused writes, second with a concurrent strobe
        push(16'hEEEE, 16'hEEEE);
        @(negedge clk);
        in_valid = 1'b1; in_left = 16'hEEEF; in_right = 16'hEEEF; out_strobe = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_strobe = 1'b0;
        check("R7 drop_count", 32'(drop_count), 32'h2);
        check("R4 first pop", 32'({out_left, out_right}), 32'hC000D000);
        check("R6 in_ready after pop", 32'(in_ready), 32'h1);
        for (int i = 1; i < DEPTH; i++) begin
            strobe();
            check("R4 order", 32'({out_left, out_right}), {16'(16'hC000 + i), 16'(16'hD000 + i)});
        end
        check("R8 no underflow yet", 32'(underflow), 32'h0);

        // R8 underflow gives zeros and sticks
        strobe();
        check("R8 zero left", 32'(out_left), 32'h0);
        check("R8 zero right", 32'(out_right), 32'h0);
        check("R8 flag set", 32'(underflow), 32'h1);
        push(16'h4242, 16'h2424);
        strobe();
        check("R8 data after underflow", 32'({out_left, out_right}), 32'h42422424);
        check("R8 flag sticky", 32'(underflow), 32'h1);

        // R1 reset clears flag and counter
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 underflow cleared", 32'(underflow), 32'h0);
        check("R1 drop cleared", 32'(drop_count), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule